// File: doc/BRIEF.md
# Deglitched Power-Good Window Monitor

This block judges a digitized regulator output voltage against an acceptance window built from the digitized target voltage. It drives an active-high power-good flag. The floor of the window is half the target and the ceiling is the target plus a fixed 80 mV margin. Both bounds are inclusive. Voltage samples arrive with a one-cycle valid strobe, and both values are in millivolts.

A sample outside the window does not pull power-good down at once. It starts a clock-tick persistence timer. Power-good falls only if no in-window sample arrives before the timer reaches a delay that defaults to 250 µs worth of clock ticks, so brief excursions are absorbed. A raw fault flag follows the window verdict of the most recent sample. It lets an observer see the excursion before the delay runs out. Power-good recovers on the first in-window sample, with no delay. Clearing the enable input forces the block to its inactive state.

Top module: `pgood_window_mon`

## Requirements
- R1: The lower bound is the target shifted right by one bit, with no rounding. A sample equal to that bound is inside the window, and a sample one millivolt below it is outside. For example, with a target of 1201 mV the bound is 600 mV.
- R2: The upper bound is the target plus 80 mV. A sample equal to that bound is inside the window, and a sample one millivolt above it is outside. The sum is formed without overflow.
- R3: On the clock edge that captures a valid out-of-window sample, `raw_fault` goes high. On the edge that captures a valid in-window sample, it goes low. Between samples it holds its value.
- R4: Take an out-of-window sample captured on edge k, with no in-window sample after it. `pg` goes low on edge k + DELAY_TICKS - 1, and stays high on every edge before that one.
- R5: A valid in-window sample captured before the delay expires keeps `pg` high and restarts the persistence timer from zero.
- R6: A valid in-window sample captured while enabled sets `pg` high on that same edge, with no delay.
- R7: While `en` is low, `pg` and `raw_fault` are forced low on the next edge, the timer is held at zero, and samples have no effect.
- R8: After synchronous reset, `pg` and `raw_fault` are low.
- R9: Further out-of-window samples while `pg` is already low keep it low. The timer saturates at DELAY_TICKS and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Monitor enable |
| smp_vld | input | 1 | Strobe that marks a valid voltage sample |
| vout_mv | input | MV_W | Measured output voltage in mV |
| vid_mv | input | MV_W | Target voltage in mV |
| pg | output | 1 | Power-good flag, active high |
| raw_fault | output | 1 | High after an out-of-window sample until the next in-window sample |

## Verification
The bench keeps the 50 MHz tick rate but lowers DELAY_US to 1, so the persistence delay becomes 50 cycles. A full excursion, its exact drop edge and an excursion cut short one cycle before expiry all fit in a few hundred cycles. With the default 250 µs delay, 12,500 cycles would pass between events. The bench also uses an odd target, which exposes the truncation of the lower bound. The default 16-bit width leaves room to probe both bounds to the millivolt.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef struct packed {
        logic below;
        logic above;
    } win_flags_t;

    typedef struct packed {
        logic hit_in;
        logic hit_out;
    } smp_kind_t;

    function automatic int unsigned ticks_for(input int unsigned clk_hz,
                                              input int unsigned delay_us);
        return (clk_hz / 1_000_000) * delay_us;
    endfunction

endpackage

// File: rtl/pgw_bounds.sv
module pgw_bounds
    import pgw_pkg::*;
#(
    parameter int MV_W      = 16,
    parameter int OFFSET_MV = 80
) (
    input  logic [MV_W-1:0] vid_mv,
    input  logic [MV_W-1:0] vout_mv,
    output win_flags_t      flags
);
    localparam int EXT_W = MV_W + 1;

    logic [EXT_W-1:0] floor_mv;
    logic [EXT_W-1:0] ceil_mv;
    logic [EXT_W-1:0] vout_ext;

    always_comb begin
        floor_mv    = {2'b00, vid_mv[MV_W-1:1]};
        ceil_mv     = {1'b0, vid_mv} + EXT_W'(OFFSET_MV);
        vout_ext    = {1'b0, vout_mv};
        flags.below = vout_ext < floor_mv;
        flags.above = vout_ext > ceil_mv;
    end
endmodule

// File: rtl/pgw_persist_timer.sv
module pgw_persist_timer
    import pgw_pkg::*;
#(
    parameter int DELAY_TICKS = 12500,
    parameter int CNT_W       = $clog2(DELAY_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  smp_kind_t        kind,
    output logic             fault_q,
    output logic             expire,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_TICKS - 1);
    localparam logic [CNT_W-1:0] TOP  = CNT_W'(DELAY_TICKS);

    logic active;

    always_comb begin
        active = kind.hit_out | (fault_q & ~kind.hit_in);
        expire = en & active & (cnt_q == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q   <= '0;
            fault_q <= 1'b0;
        end else if (kind.hit_in) begin
            cnt_q   <= '0;
            fault_q <= 1'b0;
        end else if (active) begin
            fault_q <= 1'b1;
            if (cnt_q != TOP) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pgw_flag_reg.sv
module pgw_flag_reg (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic set_good,
    input  logic drop,
    output logic good_q
);
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            good_q <= 1'b0;
        end else if (set_good) begin
            good_q <= 1'b1;
        end else if (drop) begin
            good_q <= 1'b0;
        end
    end
endmodule

// File: rtl/pgood_window_mon.sv
module pgood_window_mon
    import pgw_pkg::*;
#(
    parameter int MV_W      = 16,
    parameter int OFFSET_MV = 80,
    parameter int CLK_HZ    = 50_000_000,
    parameter int DELAY_US  = 250
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            smp_vld,
    input  logic [MV_W-1:0] vout_mv,
    input  logic [MV_W-1:0] vid_mv,
    output logic            pg,
    output logic            raw_fault
);
    localparam int DELAY_TICKS = int'(ticks_for(CLK_HZ, DELAY_US));
    localparam int CNT_W       = $clog2(DELAY_TICKS + 1);

    win_flags_t       flags;
    smp_kind_t        kind;
    logic             expire;
    logic [CNT_W-1:0] tmr_cnt;

    pgw_bounds #(.MV_W(MV_W), .OFFSET_MV(OFFSET_MV)) u_bounds (
        .vid_mv  (vid_mv),
        .vout_mv (vout_mv),
        .flags   (flags)
    );

    always_comb begin
        kind.hit_out = smp_vld & (flags.below | flags.above);
        kind.hit_in  = smp_vld & ~(flags.below | flags.above);
    end

    pgw_persist_timer #(.DELAY_TICKS(DELAY_TICKS), .CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .kind    (kind),
        .fault_q (raw_fault),
        .expire  (expire),
        .cnt_q   (tmr_cnt)
    );

    pgw_flag_reg u_flag (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .set_good (kind.hit_in),
        .drop     (expire),
        .good_q   (pg)
    );
endmodule

module pgood_window_mon_chk #(
    parameter int MV_W        = 16,
    parameter int OFFSET_MV   = 80,
    parameter int DELAY_TICKS = 12500,
    parameter int CNT_W       = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             smp_vld,
    input logic [MV_W-1:0]  vout_mv,
    input logic [MV_W-1:0]  vid_mv,
    input logic             pg,
    input logic             raw_fault,
    input logic [CNT_W-1:0] tmr_cnt
);
    logic inwin;
    always_comb begin
        inwin = (32'(vout_mv) >= 32'(vid_mv) / 2)
             && (32'(vout_mv) <= 32'(vid_mv) + 32'(OFFSET_MV));
    end

    AST_FAULT_ON_OOW: assert property (@(posedge clk) disable iff (rst)
        (en && smp_vld && !inwin) |=> raw_fault); // R3
    AST_FAULT_CLR_INWIN: assert property (@(posedge clk) disable iff (rst)
        (en && smp_vld && inwin) |=> !raw_fault); // R3
    AST_DROP_AT_DELAY: assert property (@(posedge clk) disable iff (rst)
        ($fell(pg) && $past(en)) |-> (32'(tmr_cnt) == DELAY_TICKS)); // R4
    AST_TMR_CLR_INWIN: assert property (@(posedge clk) disable iff (rst)
        (en && smp_vld && inwin) |=> (tmr_cnt == '0)); // R5
    AST_RISE_INWIN: assert property (@(posedge clk) disable iff (rst)
        (en && smp_vld && inwin) |=> pg); // R6
    AST_OFF_WHEN_DIS: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!pg && !raw_fault && tmr_cnt == '0)); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        32'(tmr_cnt) <= DELAY_TICKS); // R9
endmodule

bind pgood_window_mon pgood_window_mon_chk #(
    .MV_W(MV_W), .OFFSET_MV(OFFSET_MV),
    .DELAY_TICKS(DELAY_TICKS), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .en(en), .smp_vld(smp_vld),
    .vout_mv(vout_mv), .vid_mv(vid_mv), .pg(pg),
    .raw_fault(raw_fault), .tmr_cnt(tmr_cnt)
);

// File: tb/pgood_window_mon_bench.sv
module pgood_window_mon_bench;
    localparam int MV_W  = 16;
    localparam int DELAY = 50;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            en = 1'b0;
    logic            smp_vld = 1'b0;
    logic [MV_W-1:0] vout_mv = '0;
    logic [MV_W-1:0] vid_mv = '0;
    logic            pg;
    logic            raw_fault;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    string cur_req = "R8";

    typedef struct {
        bit    exp_pg;
        bit    exp_flt;
        string req;
    } exp_t;
    exp_t sb_q[$];

    bit m_pg = 0, m_flt = 0;
    int m_cnt = 0;

    always #10 clk = ~clk;

    pgood_window_mon #(.MV_W(MV_W), .DELAY_US(1)) u_pgood_window_mon (
        .clk(clk), .rst(rst), .en(en), .smp_vld(smp_vld),
        .vout_mv(vout_mv), .vid_mv(vid_mv), .pg(pg), .raw_fault(raw_fault)
    );

    task automatic check(input bit act, input bit exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic step(input bit e, input bit v, input int vo, input int vi);
        bit inw;
        @(negedge clk);
        en = e; smp_vld = v; vout_mv = MV_W'(vo); vid_mv = MV_W'(vi);
        inw = (vo >= vi / 2) && (vo <= vi + 80);
        if (!e) begin
            m_pg = 0; m_flt = 0; m_cnt = 0;
        end else if (v && inw) begin
            m_pg = 1; m_flt = 0; m_cnt = 0;
        end else if ((v && !inw) || m_flt) begin
            m_flt = 1;
            if (m_cnt < DELAY) m_cnt++;
            if (m_cnt == DELAY) m_pg = 0;
        end
        sb_q.push_back('{m_pg, m_flt, cur_req});
    endtask

    task automatic idle(input int n, input int vi);
        for (int i = 0; i < n; i++) step(1, 0, 0, vi);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (pg !== e.exp_pg || raw_fault !== e.exp_flt) begin
                    n_fail++;
                    $display("FAIL %s pg/raw_fault actual=%0b/%0b expected=%0b/%0b t=%0t",
                             e.req, pg, raw_fault, e.exp_pg, e.exp_flt, $time);
                end
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(200_000 * 20);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        cur_req = "R8";
        check(pg, 1'b0, "pg after reset");
        check(raw_fault, 1'b0, "raw_fault after reset");
        @(negedge clk);
        rst = 1'b0;

        cur_req = "R6";
        step(1, 0, 0, 1200);
        step(1, 1, 1000, 1200);
        idle(3, 1200);

        cur_req = "R1";
        step(1, 1, 600, 1200);
        step(1, 1, 599, 1200);
        step(1, 1, 600, 1201);
        step(1, 1, 599, 1201);
        step(1, 1, 1100, 1201);

        cur_req = "R2";
        step(1, 1, 1280, 1200);
        step(1, 1, 1281, 1200);
        step(1, 1, 65535, 65535);
        step(1, 1, 1200, 1200);

        cur_req = "R3";
        step(1, 1, 2000, 1200);
        idle(5, 1200);
        step(1, 1, 1190, 1200);
        idle(3, 1200);

        cur_req = "R5";
        step(1, 1, 100, 1200);
        idle(DELAY - 3, 1200);
        step(1, 1, 1200, 1200);
        step(1, 1, 100, 1200);
        idle(10, 1200);
        step(1, 1, 1200, 1200);

        cur_req = "R4";
        step(1, 1, 3000, 1200);
        idle(DELAY + 5, 1200);

        cur_req = "R9";
        for (int i = 0; i < 20; i++) step(1, 1, 50, 1200);
        idle(10, 1200);

        cur_req = "R6";
        step(1, 1, 1250, 1200);
        idle(2, 1200);

        cur_req = "R7";
        step(0, 1, 1000, 1200);
        step(0, 1, 100, 1200);
        step(0, 0, 0, 1200);
        step(1, 0, 0, 1200);
        idle(3, 1200);
        step(1, 1, 1000, 1200);
        step(1, 1, 100, 1200);
        step(0, 0, 0, 1200);
        step(1, 0, 0, 1200);
        idle(DELAY + 2, 1200);

        @(posedge clk); @(posedge clk); #2;
        done = 1'b1;
        finish_run();
    end
endmodule